// File: doc/BRIEF.md
# Looped Micro-Program Step Walker

This block expands one compact 128-bit control row into a stream of sequencer steps. When a start pulse arrives while it is idle, it captures the row and unpacks its low six bytes into four 12-bit step bodies. It reads them as a nibble stream, low nibble of each byte first, and builds each body from three nibbles with the first nibble least significant. It also derives a repeat count from the tail bytes and takes a 48-bit loop payload from the upper part of the row.

The walker then issues the four bodies in order and repeats the whole group count+1 times. Every step goes out with the same payload over a valid/ready handshake. A one-cycle done pulse marks the end of the program. The bodies are forwarded as they are and not interpreted, so the default advance body 0x30c passes through like any other value. Start pulses that arrive while a program is running are dropped.

Top module: `step_walker`

## Requirements
- R1: During and right after reset, `step_valid_o` and `done_o` are low.
- R2: Step body k (k = 0..3) is row bits [12k+11:12k]. This is nibbles 3k, 3k+1 and 3k+2 of the stream, where nibble n is the low nibble of byte n/2 for even n and the high nibble for odd n, and the first nibble is the least significant. Byte sequence 0c c3 30 therefore yields body 0x30c.
- R3: Within each iteration the four bodies are issued in the order 0, 1, 2, 3. At most one step is issued per cycle.
- R4: The repeat count is byte 7 (row bits [63:56]) when that byte is nonzero; otherwise it is byte 6 (row bits [55:48]).
- R5: The four-step group is issued exactly count+1 times. Counts 0, 1, 2, 3, 7, 10, 15 and 255 are all supported.
- R6: Every issued step carries bytes 8 to 13 (row bits [111:64]) on `step_payload_o`. Bytes 14 and 15 have no effect on any output.
- R7: While `step_valid_o` is high and `step_ready_i` is low, the valid, body and payload outputs hold steady in the next cycle.
- R8: `done_o` is high for exactly one cycle, in the cycle after the handshake of the last step of the last iteration, and `step_valid_o` is low in that cycle.
- R9: A start that arrives while a step is pending or while `done_o` is high is ignored.
- R10: A start accepted in the idle state makes step 0 valid in the next cycle.
- R11: The row is sampled only in the cycle its start is accepted. Later changes on `row_i` have no effect on the running program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a program with the row on `row_i` |
| row_i | input | 128 | Slow control row |
| step_ready_i | input | 1 | Consumer accepts the current step |
| step_valid_o | output | 1 | A step is presented |
| step_body_o | output | 12 | 12-bit step body |
| step_payload_o | output | 48 | Loop payload that goes with the step |
| done_o | output | 1 | One-cycle end-of-program pulse |

## Verification
The hardest situation to reach is a start that lands exactly in the done cycle, or one that lands during a stalled final step. It should be ignored there, yet one cycle later it would launch a new program. The bench drives a start with a fresh, different row on random cycles throughout each program, under a random ready pattern, so these edges are hit repeatedly. A cycle-by-cycle queue model then catches any extra or missing steps. Programs with the largest count and with byte 7 overriding byte 6 exercise the iteration counter at both ends of its range.

// File: rtl/walker_pkg.sv
package walker_pkg;
  localparam int ROW_W      = 128;
  localparam int NIB_W      = 4;
  localparam int NIBS_STEP  = 3;
  localparam int STEP_W     = NIB_W * NIBS_STEP;
  localparam int NUM_STEPS  = 4;
  localparam int IDX_W      = $clog2(NUM_STEPS);
  localparam int CNT_W      = 8;
  localparam int CNT_LO_LSB = 48;
  localparam int CNT_HI_LSB = 56;
  localparam int PAY_LSB    = 64;
  localparam int PAY_W      = 48;

  typedef struct packed {
    logic [NUM_STEPS-1:0][STEP_W-1:0] bodies;
    logic [CNT_W-1:0]                 count;
    logic [PAY_W-1:0]                 payload;
  } prog_t;

  // Nibbles are contiguous little-endian, so step k is one 12-bit slice.
  function automatic logic [STEP_W-1:0] step_body(input logic [ROW_W-1:0] row, input int k);
    return row[k*STEP_W +: STEP_W];
  endfunction

  function automatic logic [CNT_W-1:0] rep_count(input logic [ROW_W-1:0] row);
    logic [CNT_W-1:0] hi;
    hi = row[CNT_HI_LSB +: CNT_W];
    return (hi != '0) ? hi : row[CNT_LO_LSB +: CNT_W];
  endfunction

  function automatic logic [PAY_W-1:0] loop_payload(input logic [ROW_W-1:0] row);
    return row[PAY_LSB +: PAY_W];
  endfunction
endpackage

// File: rtl/walker_row_unpack.sv
module walker_row_unpack
  import walker_pkg::*;
(
  input  logic [ROW_W-1:0] row_i,
  output prog_t            prog_o
);
  for (genvar k = 0; k < NUM_STEPS; k++) begin : g_step
    assign prog_o.bodies[k] = step_body(row_i, k);
  end
  assign prog_o.count   = rep_count(row_i);
  assign prog_o.payload = loop_payload(row_i);
endmodule

// File: rtl/walker_prog_reg.sv
module walker_prog_reg
  import walker_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  prog_t prog_i,
  output prog_t prog_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prog_o <= '0;
    else if (load_i) prog_o <= prog_i;
  end
endmodule

// File: rtl/walker_seq.sv
module walker_seq
  import walker_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ready_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             valid_o,
  output logic             done_o,
  output logic             accept_o,
  output logic             last_hs_o,
  output logic [IDX_W-1:0] idx_o
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_t;
  state_t           state_q;
  logic [CNT_W-1:0] iter_q;
  logic             hs, last_step, last_iter;

  assign valid_o   = (state_q == S_RUN);
  assign done_o    = (state_q == S_DONE);
  assign accept_o  = (state_q == S_IDLE) && start_i;
  assign hs        = valid_o && ready_i;
  assign last_step = (idx_o == IDX_W'(NUM_STEPS - 1));
  assign last_iter = (iter_q == count_i);
  assign last_hs_o = hs && last_step && last_iter;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_o   <= '0;
      iter_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_RUN;
          idx_o   <= '0;
          iter_q  <= '0;
        end
        S_RUN: if (hs) begin
          if (last_step) begin
            idx_o <= '0;
            if (last_iter) state_q <= S_DONE;
            else           iter_q  <= iter_q + 1'b1;
          end else begin
            idx_o <= idx_o + 1'b1;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/step_walker.sv
module step_walker
  import walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              step_ready_i,
  output logic              step_valid_o,
  output logic [STEP_W-1:0] step_body_o,
  output logic [PAY_W-1:0]  step_payload_o,
  output logic              done_o
);
  prog_t            unpacked_w, prog_w;
  logic             accept_w, last_hs_w;
  logic [IDX_W-1:0] step_idx_w;

  walker_row_unpack u_unpack (.row_i(row_i), .prog_o(unpacked_w));

  walker_prog_reg u_prog (
    .clk(clk), .rst_n(rst_n), .load_i(accept_w),
    .prog_i(unpacked_w), .prog_o(prog_w)
  );

  walker_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_i(step_ready_i),
    .count_i(prog_w.count), .valid_o(step_valid_o), .done_o(done_o),
    .accept_o(accept_w), .last_hs_o(last_hs_w), .idx_o(step_idx_w)
  );

  assign step_body_o    = prog_w.bodies[step_idx_w];
  assign step_payload_o = prog_w.payload;
endmodule

// File: rtl/step_walker_chk.sv
module step_walker_chk
  import walker_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              step_ready_i,
  input logic              step_valid_o,
  input logic [STEP_W-1:0] step_body_o,
  input logic [PAY_W-1:0]  step_payload_o,
  input logic              done_o,
  input logic              accept_w,
  input logic              last_hs_w,
  input logic [IDX_W-1:0]  step_idx_w
);
  a_r10_first_step: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> step_valid_o && (step_idx_w == '0));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid_o && !step_ready_i |=> step_valid_o && $stable(step_body_o) && $stable(step_payload_o));

  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_hs_w |=> done_o);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !step_valid_o);

  a_r9_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid_o || done_o) |-> !accept_w);

  a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid_o && step_ready_i && (step_idx_w != IDX_W'(NUM_STEPS - 1))
      |=> step_idx_w == IDX_W'($past(step_idx_w) + 1'b1));

  a_r6_payload_steady: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid_o && step_ready_i && !last_hs_w |=> $stable(step_payload_o));
endmodule

bind step_walker step_walker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .step_ready_i(step_ready_i),
  .step_valid_o(step_valid_o), .step_body_o(step_body_o),
  .step_payload_o(step_payload_o), .done_o(done_o),
  .accept_w(accept_w), .last_hs_w(last_hs_w), .step_idx_w(step_idx_w)
);

// File: tb/step_walker_tb.sv
module step_walker_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] row_i = '0;
  logic         step_ready_i = 1'b0;
  logic         step_valid_o;
  logic [11:0]  step_body_o;
  logic [47:0]  step_payload_o;
  logic         done_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  step_walker dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .row_i(row_i),
    .step_ready_i(step_ready_i), .step_valid_o(step_valid_o),
    .step_body_o(step_body_o), .step_payload_o(step_payload_o), .done_o(done_o)
  );

  // Reference model: queue of expected {body, payload} steps.
  logic [59:0] exp_q[$];
  bit exp_done = 1'b0;
  int handshakes = 0;
  int exp_total = 0;
  bit model_on = 1'b0;

  function automatic logic [11:0] ref_body(input logic [127:0] r, input int k);
    logic [11:0] b;
    b = '0;
    for (int j = 0; j < 3; j++) begin
      int n;
      logic [7:0] by;
      logic [3:0] nib;
      n   = 3 * k + j;
      by  = r[8 * (n / 2) +: 8];
      nib = (n % 2 == 0) ? by[3:0] : by[7:4];
      b   = b | (12'(nib) << (4 * j));
    end
    return b;
  endfunction

  // R4: tail byte 7 wins unless it is zero.
  function automatic int ref_count(input logic [127:0] r);
    if (r[63:56] == 8'd0) return int'(r[55:48]);
    return int'(r[63:56]);
  endfunction

  function automatic logic [47:0] ref_payload(input logic [127:0] r);
    logic [47:0] p;
    for (int i = 0; i < 6; i++) p[8*i +: 8] = r[8*(8+i) +: 8];
    return p;
  endfunction

  function automatic bit model_idle();
    return (exp_q.size() == 0) && !exp_done;
  endfunction

  task automatic check(input bit ok, input string what, input string act, input string exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      bit nd;
      check(step_valid_o == (exp_q.size() != 0), "R3 R5 R9 R10 valid",
            $sformatf("%0b", step_valid_o), $sformatf("%0b", exp_q.size() != 0));
      if (exp_q.size() != 0 && step_valid_o) begin
        check(step_body_o == exp_q[0][59:48], "R2 R3 R11 body",
              $sformatf("%03h", step_body_o), $sformatf("%03h", exp_q[0][59:48]));
        check(step_payload_o == exp_q[0][47:0], "R6 R11 payload",
              $sformatf("%012h", step_payload_o), $sformatf("%012h", exp_q[0][47:0]));
      end
      check(done_o == exp_done, "R8 done",
            $sformatf("%0b", done_o), $sformatf("%0b", exp_done));
      if (exp_done)
        check(handshakes == exp_total, "R5 step total",
              $sformatf("%0d", handshakes), $sformatf("%0d", exp_total));
      // Predict the next cycle from the inputs driven after the last posedge.
      nd = 1'b0;
      if (start_i && model_idle()) begin
        int c;
        c = ref_count(row_i);
        exp_total = 4 * (c + 1);
        handshakes = 0;
        for (int it = 0; it <= c; it++)
          for (int k = 0; k < 4; k++)
            exp_q.push_back({ref_body(row_i, k), ref_payload(row_i)});
      end else if (exp_q.size() != 0 && step_ready_i) begin
        void'(exp_q.pop_front());
        handshakes++;
        if (exp_q.size() == 0) nd = 1'b1;
      end
      exp_done = nd;
    end
  end

  int ready_mode = 0;
  bit pester = 1'b0;

  task automatic drive_cycle(input bit st, input logic [127:0] r);
    @(posedge clk);
    #1;
    start_i = st;
    row_i = r;
    case (ready_mode)
      0: step_ready_i = 1'b1;
      1: step_ready_i = ~step_ready_i;
      default: step_ready_i = ($urandom % 3) != 0;
    endcase
  endtask

  function automatic logic [127:0] junk_row();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Junk start pulses with other rows while busy: R9, R11.
  task automatic run_prog(input logic [127:0] r);
    int guard;
    drive_cycle(1'b1, r);
    guard = 0;
    while (!model_idle() && guard < 5000) begin
      logic [127:0] jr;
      jr = junk_row();
      drive_cycle(pester && ($urandom % 2 == 0), jr);
      guard++;
    end
    drive_cycle(1'b0, junk_row());
  endtask

  function automatic logic [127:0] make_row(input logic [7:0] b6, input logic [7:0] b7);
    logic [127:0] r;
    r = junk_row();
    r[55:48] = b6;
    r[63:56] = b7;
    return r;
  endfunction

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cnts[7];
    logic [127:0] r;
    cnts = '{0, 1, 2, 3, 7, 10, 15};
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!step_valid_o && !done_o, "R1 reset outputs",
          $sformatf("%0b%0b", step_valid_o, done_o), "00");
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check(!step_valid_o && !done_o, "R1 after reset",
          $sformatf("%0b%0b", step_valid_o, done_o), "00");
    model_on = 1'b1;

    // R2: default backbone row, bytes 0c c3 30 0c c3 30, count 1
    r = make_row(8'd1, 8'd0);
    r[47:0] = 48'h30c30c30c30c;
    ready_mode = 0;
    run_prog(r);

    // R5: every required count, with each ready pattern
    for (int m = 0; m < 3; m++) begin
      ready_mode = m;
      foreach (cnts[i]) run_prog(make_row(8'(cnts[i]), 8'd0));
    end

    // R4: byte 7 nonzero overrides byte 6
    ready_mode = 2;
    run_prog(make_row(8'd9, 8'd5));
    run_prog(make_row(8'd0, 8'd3));

    // R9, R11, R6: busy starts with other rows, junk in bytes 14-15
    pester = 1'b1;
    for (int i = 0; i < 6; i++) begin
      ready_mode = i % 3;
      run_prog(make_row(8'(i), 8'd0));
    end
    // R5: largest count
    ready_mode = 0;
    run_prog(make_row(8'd255, 8'd0));
    pester = 1'b0;
    repeat (4) drive_cycle(1'b0, junk_row());

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule